// File: doc/BRIEF.md
# Processor Input Buffer Enable Logic

This block decides when the buffer that moves data from the system data bus onto the processor's raw data pins may conduct. The processor sees bus data only while it is reading, or while it has granted the bus to a DMA master, and only while the front panel is in run or single-step mode. In stop mode the buffer stays shut. The panel can then place bytes on the raw bus through open-drain drivers and pull-ups without fighting memory or I/O. Memory is never disabled, so panel lamps on the buffered side still show what memory returns.

The block also produces an active-low sense-switch disable. It is asserted when the processor reads input port 255, so that the panel switches on the raw bus supply the byte. While it is asserted the buffer is forced off. The port compare uses the low byte of the address. It is qualified by an input-cycle status bit that is latched on a status strobe.

All inputs are registered once, behind a synchronously released reset. Both outputs are pure combinational decodes of those registers.

Top module: `ibuf_enable_ctl`

## Requirements
- R1: While reset is asserted, and until the first sampling edge after release, buf_en is 0 and sense_dis_n is 1.
- R2: buf_en is 1 only if rd_strobe or hold_ack was high at the previous sampling edge.
- R3: buf_en is 1 only if run_mode or step_mode was high at the previous sampling edge. With both low (stop), buf_en is 0.
- R4: Whenever sense_dis_n is 0, buf_en is 0. In every other case buf_en = (rd or hold) and (run or step), using the sampled values.
- R5: sense_dis_n is 0 exactly when the sampled rd_strobe is 1, the latched input-cycle bit is 1, and the sampled addr[7:0] equals 8'hFF. Address bits above bit 7 have no effect.
- R6: The input-cycle bit is loaded from in_cycle on an edge where status_strobe is 1. It holds its value on every other edge.
- R7: The outputs follow the inputs with one clock of latency. A change on the inputs does not reach the outputs before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_strobe | input | 1 | Processor data-in strobe |
| hold_ack | input | 1 | Hold acknowledge (bus granted for DMA) |
| run_mode | input | 1 | Panel in run mode |
| step_mode | input | 1 | Panel in single-step mode |
| in_cycle | input | 1 | Input-port cycle status |
| status_strobe | input | 1 | Loads in_cycle into the held status bit |
| addr | input | ADDR_W | Processor address bus |
| buf_en | output | 1 | Input buffer enable, active high |
| sense_dis_n | output | 1 | Sense-switch disable, active low |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit port compare and a sense port of 255. With these values every pairing of strobe, hold, run, step, status and port-hit is enumerated directly. Random upper address bits on both matching and non-matching low bytes show that only the low byte is decoded. Random cycles with a random status strobe check that the latched status bit is held between strobes. One directed sequence probes the outputs just before and just after an edge to confirm the single register stage.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

  // One sampled set of processor and panel control inputs
  typedef struct packed {
    logic rd;
    logic hold;
    logic run;
    logic step;
  } ctl_t;

  localparam int unsigned DEF_ADDR_W     = 16;
  localparam int unsigned DEF_PORT_W     = 8;
  localparam int unsigned DEF_SENSE_PORT = 255;

endpackage

// File: rtl/ibuf_rst_sync.sv
module ibuf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ibuf_in_stage.sv
module ibuf_in_stage
  import ibuf_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned PORT_W = DEF_PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl_in,
  input  logic              in_cycle,
  input  logic              status_strobe,
  input  logic [ADDR_W-1:0] addr,
  output ctl_t              ctl_q,
  output logic              stat_q,
  output logic [PORT_W-1:0] port_q
);

  ctl_t              ctl_d;
  logic              stat_d;
  logic              stat_en;
  logic [PORT_W-1:0] port_d;

  always_comb begin
    ctl_d   = ctl_in;
    port_d  = addr[PORT_W-1:0];
    stat_en = status_strobe;
    stat_d  = stat_en ? in_cycle : stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      stat_q <= 1'b0;
      port_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
      port_q <= port_d;
    end
  end

endmodule

// File: rtl/ibuf_port_match.sv
module ibuf_port_match #(
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned SENSE_PORT = 255
) (
  input  logic [PORT_W-1:0] port_q,
  output logic              hit
);

  localparam logic [PORT_W-1:0] TARGET = PORT_W'(SENSE_PORT);

  logic [PORT_W-1:0] bit_eq;

  generate
    for (genvar i = 0; i < PORT_W; i++) begin : g_bit
      assign bit_eq[i] = ~(port_q[i] ^ TARGET[i]);
    end
  endgenerate

  assign hit = &bit_eq;

endmodule

// File: rtl/ibuf_gate.sv
module ibuf_gate
  import ibuf_pkg::*;
(
  input  ctl_t ctl_q,
  input  logic stat_q,
  input  logic port_hit,
  output logic buf_en,
  output logic sense_dis_n
);

  logic xfer_req;
  logic mode_ok;
  logic sense_rd;

  always_comb begin
    xfer_req    = ctl_q.rd | ctl_q.hold;
    mode_ok     = ctl_q.run | ctl_q.step;
    sense_rd    = ctl_q.rd & stat_q & port_hit;
    sense_dis_n = ~sense_rd;
    buf_en      = xfer_req & mode_ok & sense_dis_n;
  end

endmodule

// File: rtl/ibuf_enable_ctl.sv
module ibuf_enable_ctl
  import ibuf_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned PORT_W     = DEF_PORT_W,
  parameter int unsigned SENSE_PORT = DEF_SENSE_PORT,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              rd_strobe,
  input  logic              hold_ack,
  input  logic              run_mode,
  input  logic              step_mode,
  input  logic              in_cycle,
  input  logic              status_strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              buf_en,
  output logic              sense_dis_n
);

  logic              rst_n_sync;
  ctl_t              ctl_in;
  ctl_t              ctl_q;
  logic              stat_q;
  logic [PORT_W-1:0] port_q;
  logic              port_hit;

  assign ctl_in = '{rd: rd_strobe, hold: hold_ack, run: run_mode, step: step_mode};

  ibuf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_sync)
  );

  ibuf_in_stage #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_in (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .ctl_in        (ctl_in),
    .in_cycle      (in_cycle),
    .status_strobe (status_strobe),
    .addr          (addr),
    .ctl_q         (ctl_q),
    .stat_q        (stat_q),
    .port_q        (port_q)
  );

  ibuf_port_match #(.PORT_W(PORT_W), .SENSE_PORT(SENSE_PORT)) u_match (
    .port_q (port_q),
    .hit    (port_hit)
  );

  ibuf_gate u_gate (
    .ctl_q       (ctl_q),
    .stat_q      (stat_q),
    .port_hit    (port_hit),
    .buf_en      (buf_en),
    .sense_dis_n (sense_dis_n)
  );

endmodule

// File: rtl/ibuf_enable_chk.sv
module ibuf_enable_chk
  import ibuf_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic rd_strobe,
  input logic hold_ack,
  input logic run_mode,
  input logic step_mode,
  input logic status_strobe,
  input ctl_t ctl_q,
  input logic stat_q,
  input logic port_hit,
  input logic buf_en,
  input logic sense_dis_n
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!buf_en && sense_dis_n));

  assert_needs_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> (ctl_q.rd || ctl_q.hold));

  assert_needs_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> (ctl_q.run || ctl_q.step));

  assert_sense_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_dis_n |-> !buf_en);

  assert_sense_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_dis_n |-> (ctl_q.rd && stat_q && port_hit));

  assert_stat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !status_strobe |=> $stable(stat_q));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> ($past(rd_strobe || hold_ack) && $past(run_mode || step_mode)));

endmodule

bind ibuf_enable_ctl ibuf_enable_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .rd_strobe     (rd_strobe),
  .hold_ack      (hold_ack),
  .run_mode      (run_mode),
  .step_mode     (step_mode),
  .status_strobe (status_strobe),
  .ctl_q         (ctl_q),
  .stat_q        (stat_q),
  .port_hit      (port_hit),
  .buf_en        (buf_en),
  .sense_dis_n   (sense_dis_n)
);

// File: tb/sim_ibuf_enable_ctl.sv
module sim_ibuf_enable_ctl;

  localparam int unsigned ADDR_W = 16;

  logic              clk = 1'b0;
  logic              arst_n;
  logic              rd_strobe, hold_ack, run_mode, step_mode, in_cycle, status_strobe;
  logic [ADDR_W-1:0] addr;
  logic              buf_en, sense_dis_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic stat_m;

  always #5 clk = ~clk;

  ibuf_enable_ctl u0 (
    .clk(clk), .arst_n(arst_n), .rd_strobe(rd_strobe), .hold_ack(hold_ack),
    .run_mode(run_mode), .step_mode(step_mode), .in_cycle(in_cycle),
    .status_strobe(status_strobe), .addr(addr),
    .buf_en(buf_en), .sense_dis_n(sense_dis_n)
  );

  function automatic logic exp_sense_n(logic rd, logic st, logic [ADDR_W-1:0] a);
    return !(rd && st && (a[7:0] == 8'hFF));
  endfunction

  function automatic logic exp_buf(logic rd, logic hd, logic rn, logic sp, logic sn);
    return (rd || hd) && (rn || sp) && sn;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic rd, logic hd, logic rn, logic sp, logic ic, logic sb,
                       logic [ADDR_W-1:0] a);
    rd_strobe = rd; hold_ack = hd; run_mode = rn; step_mode = sp;
    in_cycle = ic; status_strobe = sb; addr = a;
  endtask

  task automatic step_check(string tag);
    @(posedge clk);
    if (status_strobe) stat_m = in_cycle;
    @(negedge clk);
    check({tag, " sense R5"}, sense_dis_n, exp_sense_n(rd_strobe, stat_m, addr));
    check({tag, " buf R2/R3/R4"}, buf_en,
          exp_buf(rd_strobe, hold_ack, run_mode, step_mode,
                  exp_sense_n(rd_strobe, stat_m, addr)));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    stat_m = 1'b0;
    // R1: reset with every input active
    arst_n = 1'b0;
    drive(1, 1, 1, 1, 1, 1, 16'h00FF);
    repeat (3) @(negedge clk);
    check("R1 buf in reset", buf_en, 1'b0);
    check("R1 sense in reset", sense_dis_n, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 16'h0000);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    stat_m = 1'b0;
    check("R1 buf after release", buf_en, 1'b0);
    check("R1 sense after release", sense_dis_n, 1'b1);

    // Exhaustive: rd, hold, run, step, status, port hit (R2 R3 R4 R5)
    for (int v = 0; v < 64; v++) begin
      logic [ADDR_W-1:0] a;
      a = v[5] ? {8'($urandom), 8'hFF} : {8'($urandom), 8'($urandom_range(0, 254))};
      drive(v[0], v[1], v[2], v[3], v[4], 1'b1, a);
      step_check("exhaustive");
    end

    // R5: upper address bits have no effect
    drive(1, 0, 1, 0, 1, 1, 16'hA5FF); step_check("R5 upper A5");
    check("R5 port FF with upper A5", sense_dis_n, 1'b0);
    drive(1, 0, 1, 0, 1, 1, 16'hFFFE); step_check("R5 upper FF");
    check("R5 port FE with upper FF", sense_dis_n, 1'b1);

    // R3: stop mode keeps buffer off during a read
    drive(1, 1, 0, 0, 0, 1, 16'h1234); step_check("R3 stop");
    check("R3 stop buf", buf_en, 1'b0);

    // R6: status held when strobe low
    drive(1, 0, 1, 0, 1, 1, 16'h00FF); step_check("R6 load");
    drive(1, 0, 1, 0, 0, 0, 16'h00FF); step_check("R6 hold1");
    check("R6 held status still decodes", sense_dis_n, 1'b0);
    drive(1, 0, 1, 0, 0, 1, 16'h00FF); step_check("R6 reload");
    check("R6 cleared status", sense_dis_n, 1'b1);
    drive(1, 0, 1, 0, 1, 0, 16'h00FF); step_check("R6 hold0");
    check("R6 held zero status", sense_dis_n, 1'b1);

    // R7: one-clock latency
    drive(0, 0, 0, 0, 0, 1, 16'h0000); step_check("R7 idle");
    drive(0, 1, 0, 1, 0, 1, 16'h0000);
    #2;
    check("R7 before edge", buf_en, 1'b0);
    step_check("R7 after edge");
    check("R7 after edge buf", buf_en, 1'b1);

    // Random mix, status strobe random (R2 R3 R4 R5 R6)
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom_range(0, 2) == 0) ? {8'($urandom), 8'hFF} : ADDR_W'($urandom);
      drive(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), a);
      step_check("random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule